// File: doc/BRIEF.md
# Supply Window Protection Sequencer

This block decides when a load switch may join a system rail to its supply input, and when a health flag tells the rest of the system that the input is usable. It receives each clock cycle a digitized input-voltage sample in millivolts and an active-high shutdown request. It drives a gate-enable output for the switch and a flag that is high only while the input is healthy. The analog sensing, the switch itself and the pin drivers sit outside.

The sample is judged against a low trip point and a high trip point, each with its own hysteresis memory. A sample that lies strictly inside the window counts as valid. After a run of consecutive valid samples the switch closes, unless shutdown is requested. A second, separate delay after that moment releases the flag. Any invalid sample opens the switch and lowers the flag on the same clock edge that samples it, and the sequence restarts from the beginning. Shutdown only opens the switch. The flag timing and value follow input validity whether or not shutdown is requested.

Both trip points, both hysteresis widths and both delays (in clock cycles) are parameters. The defaults are a 2950 mV low trip with 60 mV hysteresis, a 6020 mV high trip with 70 mV hysteresis, and two delays of 2,000,000 cycles each.

Top module: `supply_guard_seq`

## Requirements
- R1: A sample is valid only when it is above UV_TRIP_MV and below OV_TRIP_MV. A sample equal to either trip point is a fault.
- R2: A fault sample drives gate_on and flag_ok low on the clock edge that samples it. The qualification count restarts at zero, so ON_DELAY_CYC fresh valid samples are needed again. A fault on the edge that would have reached the count wins.
- R3: With shdn low, gate_on rises on the edge that samples the ON_DELAY_CYC-th consecutive valid sample.
- R4: flag_ok rises FLAG_DELAY_CYC clock edges after the edge on which the turn-on count completed, provided every sample in between is valid.
- R5: shdn high opens gate_on at the next edge. It does not change when flag_ok rises, nor when flag_ok falls on a fault.
- R6: Once the low memory is in fault, the input counts as valid again only when a sample exceeds UV_TRIP_MV + UV_HYST_MV (3010 mV by default).
- R7: Once the high memory is in fault, the input counts as valid again only when a sample falls below OV_TRIP_MV - OV_HYST_MV (5950 mV by default).
- R8: A fault during the flag delay opens the switch and keeps the flag low. The next attempt reruns both delays in full.
- R9: Reset, synchronous and active high, leaves gate_on and flag_ok low, clears both counts and puts both hysteresis memories in the fault state.
- R10: If shdn falls while the turn-on count has already completed and the input stays valid, gate_on rises on the next edge without a new turn-on delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vin_mv | input | VIN_W | Input-voltage sample in millivolts, unsigned |
| shdn | input | 1 | Shutdown request, active high; opens the switch only |
| gate_on | output | 1 | Registered switch enable, high closes the switch |
| flag_ok | output | 1 | Registered health flag, high when the input is healthy and qualified |

## Verification
Two events can land on the same edge: the completion of a delay count and a fault sample. The bench runs seven valid samples and then puts a sample exactly at the low trip point on the edge where the turn-on count would complete. It expects the switch to stay open and the next seven valid samples to leave it open as well. It also releases shutdown and applies a fault in neighbouring cycles during the flag delay, and checks that the shutdown level never moves the flag edge. The expected gate and flag values come from edge counts worked out from the requirements.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  typedef enum logic [1:0] {
    PH_QUAL  = 2'd0,  // counting valid samples toward turn-on
    PH_START = 2'd1,  // switch allowed, counting toward flag release
    PH_OK    = 2'd2   // flag released
  } phase_t;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sgs_hyst_cmp.sv
module sgs_hyst_cmp #(
  parameter int unsigned W     = 16,
  parameter int unsigned TRIP  = 2950,
  parameter int unsigned HYST  = 60,
  parameter bit          UPPER = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  output logic         fault_nx,
  output logic         fault_q
);
  localparam logic [W-1:0] TRIP_V = W'(TRIP);
  localparam logic [W-1:0] REL_V  = UPPER ? W'(TRIP - HYST) : W'(TRIP + HYST);

  logic trip_hit, recov;

  generate
    if (UPPER) begin : g_over
      assign trip_hit = (smp >= TRIP_V);
      assign recov    = (smp <  REL_V);
    end else begin : g_under
      assign trip_hit = (smp <= TRIP_V);
      assign recov    = (smp >  REL_V);
    end
  endgenerate

  // fault memory: sticky until the release point is crossed
  assign fault_nx = fault_q ? ~recov : trip_hit;

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b1;
    else     fault_q <= fault_nx;
  end

  // R6 / R7: leaving the fault state needs the hysteresis margin
  assert_release_margin_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_q) |-> (UPPER ? ($past(smp) < REL_V) : ($past(smp) > REL_V)));
endmodule

// File: rtl/sgs_phase_timer.sv
module sgs_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] lim,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (run)    cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  // R3: count never passes the active limit
  assert_cnt_below_lim_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < lim));
endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
  import sgs_pkg::*;
#(
  parameter int unsigned VIN_W          = 16,
  parameter int unsigned UV_TRIP_MV     = 2950,
  parameter int unsigned UV_HYST_MV     = 60,
  parameter int unsigned OV_TRIP_MV     = 6020,
  parameter int unsigned OV_HYST_MV     = 70,
  parameter int unsigned ON_DELAY_CYC   = 2000000,
  parameter int unsigned FLAG_DELAY_CYC = 2000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VIN_W-1:0] vin_mv,
  input  logic             shdn,
  output logic             gate_on,
  output logic             flag_ok
);
  localparam int unsigned CNT_W = $clog2(umax(ON_DELAY_CYC, FLAG_DELAY_CYC) + 1);
  localparam logic [CNT_W-1:0] ON_LIM   = CNT_W'(ON_DELAY_CYC);
  localparam logic [CNT_W-1:0] FLAG_LIM = CNT_W'(FLAG_DELAY_CYC);

  logic uv_nx, uv_q, ov_nx, ov_q, valid_nx;
  logic tmr_clr, tmr_last;
  logic [CNT_W-1:0] lim;
  phase_t ph_q;
  logic gate_q, flag_q;

  sgs_hyst_cmp #(.W(VIN_W), .TRIP(UV_TRIP_MV), .HYST(UV_HYST_MV), .UPPER(1'b0)) u_uv (
    .clk(clk), .rst(rst), .smp(vin_mv), .fault_nx(uv_nx), .fault_q(uv_q));

  sgs_hyst_cmp #(.W(VIN_W), .TRIP(OV_TRIP_MV), .HYST(OV_HYST_MV), .UPPER(1'b1)) u_ov (
    .clk(clk), .rst(rst), .smp(vin_mv), .fault_nx(ov_nx), .fault_q(ov_q));

  // validity of the sample taken at this edge
  assign valid_nx = ~uv_nx & ~ov_nx;

  // one counter serves both delays; the phase picks the limit
  assign lim     = (ph_q == PH_QUAL) ? ON_LIM : FLAG_LIM;
  assign tmr_clr = ~valid_nx | (ph_q == PH_OK);

  sgs_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(valid_nx), .lim(lim), .last(tmr_last));

  always_ff @(posedge clk) begin
    if (rst || !valid_nx) begin
      ph_q   <= PH_QUAL;
      gate_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_QUAL: begin
          if (tmr_last) begin
            ph_q   <= PH_START;
            gate_q <= ~shdn;
          end
        end
        PH_START: begin
          gate_q <= ~shdn;
          if (tmr_last) begin
            ph_q   <= PH_OK;
            flag_q <= 1'b1;
          end
        end
        PH_OK: begin
          gate_q <= ~shdn;
          flag_q <= 1'b1;
        end
        default: ph_q <= PH_QUAL;
      endcase
    end
  end

  assign gate_on = gate_q;
  assign flag_ok = flag_q;

  // R1: closed switch implies both memories report a healthy input
  assert_gate_in_window_R1: assert property (@(posedge clk) disable iff (rst)
    gate_on |-> (~uv_q & ~ov_q));

  // R2: a fault sample leaves switch open and flag low after its edge
  assert_fault_cut_R2: assert property (@(posedge clk) disable iff (rst)
    !valid_nx |=> (!gate_on && !flag_ok));

  // R5: shutdown opens the switch at the next edge
  assert_shdn_open_R5: assert property (@(posedge clk) disable iff (rst)
    shdn |=> !gate_on);

  // R4: flag is released only out of the flag-delay phase
  assert_flag_after_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_ok) |-> ($past(ph_q) == PH_START));

  // R7: high memory releases only below the hysteresis point
  assert_ov_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ov_q) |-> ($past(vin_mv) < VIN_W'(OV_TRIP_MV - OV_HYST_MV)));
endmodule

// File: tb/sim_supply_guard_seq.sv
`timescale 1ns/1ps
module sim_supply_guard_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] vin_mv = 16'd0;
  logic        shdn = 1'b0;
  logic        gate_on, flag_ok;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  supply_guard_seq #(
    .VIN_W(16), .UV_TRIP_MV(2950), .UV_HYST_MV(60),
    .OV_TRIP_MV(6020), .OV_HYST_MV(70),
    .ON_DELAY_CYC(8), .FLAG_DELAY_CYC(5)
  ) u0 (
    .clk(clk), .rst(rst), .vin_mv(vin_mv), .shdn(shdn),
    .gate_on(gate_on), .flag_ok(flag_ok));

  // row: {req[3:0], vin[15:0], shdn, cycles[7:0], exp_gate, exp_flag}
  localparam int NV = 38;
  localparam logic [30:0] TBL [NV] = '{
    {4'd3,  16'd5000, 1'b0, 8'd7,  1'b0, 1'b0},  // R3 seven valid: still open
    {4'd3,  16'd5000, 1'b0, 8'd1,  1'b1, 1'b0},  // R3 eighth valid: closes
    {4'd4,  16'd5000, 1'b0, 8'd4,  1'b1, 1'b0},  // R4 flag not yet
    {4'd4,  16'd5000, 1'b0, 8'd1,  1'b1, 1'b1},  // R4 fifth edge: flag up
    {4'd1,  16'd6020, 1'b0, 8'd1,  1'b0, 1'b0},  // R1 exactly at high trip
    {4'd7,  16'd5960, 1'b0, 8'd20, 1'b0, 1'b0},  // R7 inside high hysteresis band
    {4'd7,  16'd5949, 1'b0, 8'd7,  1'b0, 1'b0},  // R7 released, counting
    {4'd7,  16'd5949, 1'b0, 8'd1,  1'b1, 1'b0},  // R7 closes
    {4'd1,  16'd2950, 1'b0, 8'd1,  1'b0, 1'b0},  // R1 exactly at low trip
    {4'd6,  16'd3000, 1'b0, 8'd20, 1'b0, 1'b0},  // R6 inside low hysteresis band
    {4'd6,  16'd3011, 1'b0, 8'd8,  1'b1, 1'b0},  // R6 released, closes
    {4'd4,  16'd3011, 1'b0, 8'd2,  1'b1, 1'b0},  // R4 flag delay running
    {4'd5,  16'd3011, 1'b1, 8'd1,  1'b0, 1'b0},  // R5 shutdown opens
    {4'd5,  16'd3011, 1'b1, 8'd2,  1'b0, 1'b1},  // R5 flag still on time
    {4'd10, 16'd3011, 1'b0, 8'd1,  1'b1, 1'b1},  // R10 reconnect at once
    {4'd2,  16'd2000, 1'b0, 8'd1,  1'b0, 1'b0},  // R2 undervoltage cut
    {4'd3,  16'd4000, 1'b0, 8'd8,  1'b1, 1'b0},  // R3 closes
    {4'd4,  16'd4000, 1'b0, 8'd2,  1'b1, 1'b0},  // R4 flag delay running
    {4'd8,  16'd7000, 1'b0, 8'd1,  1'b0, 1'b0},  // R8 fault in flag delay
    {4'd8,  16'd4000, 1'b0, 8'd8,  1'b1, 1'b0},  // R8 full turn-on again
    {4'd8,  16'd4000, 1'b0, 8'd4,  1'b1, 1'b0},  // R8 full flag delay again
    {4'd8,  16'd4000, 1'b0, 8'd1,  1'b1, 1'b1},  // R8 flag up
    {4'd2,  16'd2000, 1'b0, 8'd1,  1'b0, 1'b0},  // R2 cut
    {4'd5,  16'd4000, 1'b1, 8'd8,  1'b0, 1'b0},  // R5 shutdown through turn-on
    {4'd5,  16'd4000, 1'b1, 8'd5,  1'b0, 1'b1},  // R5 flag rises while shut down
    {4'd5,  16'd2000, 1'b1, 8'd1,  1'b0, 1'b0},  // R5 flag drops while shut down
    {4'd2,  16'd4000, 1'b0, 8'd5,  1'b0, 1'b0},  // R2 partial count
    {4'd2,  16'd7000, 1'b0, 8'd1,  1'b0, 1'b0},  // R2 overvoltage blip
    {4'd2,  16'd4000, 1'b0, 8'd7,  1'b0, 1'b0},  // R2 count restarted
    {4'd2,  16'd4000, 1'b0, 8'd1,  1'b1, 1'b0},  // R2 closes after full run
    {4'd2,  16'd2000, 1'b0, 8'd1,  1'b0, 1'b0},  // R2 cut
    {4'd2,  16'd4000, 1'b0, 8'd7,  1'b0, 1'b0},  // R2 one short of turn-on
    {4'd2,  16'd2950, 1'b0, 8'd1,  1'b0, 1'b0},  // R2 fault on completing edge
    {4'd2,  16'd4000, 1'b0, 8'd7,  1'b0, 1'b0},  // R2 restarted from zero
    {4'd3,  16'd4000, 1'b0, 8'd1,  1'b1, 1'b0},  // R3 closes
    {4'd10, 16'd4000, 1'b1, 8'd3,  1'b0, 1'b0},  // R10 shut down in flag delay
    {4'd10, 16'd4000, 1'b0, 8'd1,  1'b1, 1'b0},  // R10 reconnect, no new delay
    {4'd4,  16'd4000, 1'b0, 8'd1,  1'b1, 1'b1}   // R4 flag edge unmoved
  };

  task automatic chk(input string req, input logic eg, input logic ef);
    checks++;
    if (gate_on !== eg || flag_ok !== ef) begin
      errors++;
      $display("FAIL %s: gate_on=%b flag_ok=%b expected gate_on=%b flag_ok=%b",
               req, gate_on, flag_ok, eg, ef);
    end
  endtask

  task automatic apply(input logic [15:0] v, input logic s, input int n);
    vin_mv = v;
    shdn   = s;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset state", 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][26:11], TBL[i][10], int'(TBL[i][9:2]));
      chk($sformatf("R%0d row %0d", TBL[i][30:27], i), TBL[i][1], TBL[i][0]);
    end

    // R9: reset while closed and flagged
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset mid-run", 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    apply(16'd3000, 1'b0, 20);
    chk("R9 low memory starts in fault", 1'b0, 1'b0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply(16'd5960, 1'b0, 20);
    chk("R9 high memory starts in fault", 1'b0, 1'b0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply(16'd4000, 1'b0, 7);
    chk("R9 count cleared by reset", 1'b0, 1'b0);
    apply(16'd4000, 1'b0, 1);
    chk("R9 closes after full delay", 1'b1, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule